// File: doc/BRIEF.md
# Start-Stop to Synchronous Transmit Converter

This block accepts start-stop characters on a serial input and sends them again on a synchronous serial output. The output is timed by a transmit bit clock. The input is read on each tick of a timing signal that runs sixteen times faster than the bit clock. A falling edge marks a possible start bit. The start bit is confirmed at its centre, and every later bit is read at its centre. Each character that ends with a valid stop bit is held until the transmit side can send it. It then goes out aligned to the bit clock.

The source and the synchronous channel never run at exactly the same rate. When the source is slow, the output fills the gaps with idle mark, which in effect inserts stop bits. When the source is fast, the output may send the next start bit in place of a stop bit, which deletes that stop bit. Deletion is allowed only after a minimum number of whole frames, and the extended-rate mode shortens that minimum. The higher-speed mode is for a bit clock that runs a little above nominal and never deletes stop bits. A bypass mode joins input to output directly. A line held at space for two character lengths is sent on as continuous space.

All logic runs on one system clock. The bit clock and the timing signal are level inputs in that clock domain, and the block detects their rising edges itself.

Top module: `async_sync_tx`

## Requirements
- R1: After reset, and with no character to send, the output is mark (1).
- R2: Each character with a valid stop bit is sent in the order received. It is sent as one space start bit, then its data bits with the least significant bit first, then a mark stop bit. The select `lenSel` sets the total length including start and stop: 00 gives 8 bits, 01 gives 9, 10 gives 10 and 11 gives 11. The data bits number the total minus two.
- R3: Outside bypass, the output changes only in the system-clock cycle that follows a rising edge of `txClk`.
- R4: In basic mode (`extRate`=0) with a source up to 1.0% fast, every character is delivered. Between two stop-bit deletions there are at least 8 frames sent with a stop bit.
- R5: In extended mode (`extRate`=1) with a source up to 2.3% fast, every character is delivered. Between two deletions there are at least 4 frames sent with a stop bit.
- R6: With a source up to 2.3% slow, every character is delivered, no stop bit is deleted, and the extra time is filled with mark.
- R7: With `hiSpeed`=1, no stop bit is ever deleted.
- R8: An input held at space for at least two character lengths puts continuous space on the output. Mark returns on the output after the input returns to mark.
- R9: With `bypass`=1, `dataOut` equals `dataIn` at all times.
- R10: A space pulse that ends before the start-bit centre (8 timing ticks after the edge) is ignored, and the output stays at mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmgIn | input | 1 | Oversampling timing signal, 16 times the bit rate |
| txClk | input | 1 | Synchronous transmit bit clock |
| dataIn | input | 1 | Start-stop serial input, 1 is mark |
| lenSel | input | 2 | Total character length select |
| extRate | input | 1 | 1 selects the extended-rate deletion spacing |
| bypass | input | 1 | 1 passes dataIn straight to dataOut |
| hiSpeed | input | 1 | 1 selects the higher-speed mode, which never deletes stop bits |
| dataOut | output | 1 | Synchronous serial output, 1 is mark |

## Verification
The hardest case to reach is a stop-bit deletion. It happens only after a fast source has gained about a whole bit on the synchronous clock while the frame credit is full. It also has to occur at the exact bit-clock edge where the stop bit would go out. The bench drives the input with bit lengths counted in eighths of a system-clock cycle, so the drift builds up steadily. It then sends long back-to-back character bursts at 0.8% and 2.2% fast, which forces several deletions. A decoder on the output checks that the deletions are spaced correctly and that the characters still arrive in order.

// File: rtl/async_sync_tx_pkg.sv
package async_sync_tx_pkg;
  localparam int MAX_DATA = 9;
  localparam int IDX_W    = 4;

  typedef enum logic [1:0] {OUT_MARK, OUT_SPACE, OUT_DATA} out_sel_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_STOP} tx_state_t;

  typedef struct packed {
    logic             rxShift;
    logic [IDX_W-1:0] rxIdx;
    logic             rxCommit;
    logic             txLoad;
    logic             txShift;
    logic             outWr;
    out_sel_t         outSel;
  } strobe_t;
endpackage

// File: rtl/async_sync_tx_ctrl.sv
module async_sync_tx_ctrl
  import async_sync_tx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int BASIC_GAP = 8,
  parameter int EXT_GAP   = 4,
  parameter int BRK_CHARS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tmgIn,
  input  logic       txClk,
  input  logic       dataIn,
  input  logic [1:0] lenSel,
  input  logic       extRate,
  input  logic       hiSpeed,
  output strobe_t    stb
);
  localparam int CW      = $clog2(OSR);
  localparam int BRK_MAX = BRK_CHARS * OSR * (MAX_DATA + 2);
  localparam int BW      = $clog2(BRK_MAX + 1);
  localparam int GW      = $clog2(BASIC_GAP + 1);

  logic tmgPrev, txPrev, tmgTick, txRise, rxSamp;
  rx_state_t rxState;
  tx_state_t txState;
  logic [CW-1:0]    phase;
  logic [IDX_W-1:0] bitIdx, txCnt, nData;
  logic [BW-1:0]    lowCnt, brkLimit;
  logic [GW-1:0]    credit, gapLim;
  logic holdValid, breakActive, deleteOk;

  assign tmgTick     = tmgIn & ~tmgPrev;
  assign txRise      = txClk & ~txPrev;
  assign nData       = IDX_W'(6) + IDX_W'(lenSel);
  assign brkLimit    = BW'(BRK_CHARS * OSR * (int'(lenSel) + 8));
  assign gapLim      = extRate ? GW'(EXT_GAP) : GW'(BASIC_GAP);
  assign breakActive = (lowCnt >= brkLimit);
  assign deleteOk    = holdValid && !hiSpeed && (credit >= gapLim);

  always_comb begin
    stb          = '0;
    stb.outSel   = OUT_MARK;
    stb.rxIdx    = bitIdx;
    if (tmgTick && rxState == RX_BITS && phase == CW'(OSR - 1)) begin
      stb.rxShift  = (bitIdx < nData);
      stb.rxCommit = (bitIdx == nData) && dataIn;
    end
    if (txRise) begin
      stb.outWr = 1'b1;
      unique case (txState)
        TX_IDLE: if (breakActive) stb.outSel = OUT_SPACE;
                 else if (holdValid) begin
                   stb.outSel = OUT_SPACE;
                   stb.txLoad = 1'b1;
                 end
        TX_DATA: begin
          stb.outSel  = OUT_DATA;
          stb.txShift = 1'b1;
        end
        TX_STOP: if (deleteOk) begin
                   stb.outSel = OUT_SPACE;
                   stb.txLoad = 1'b1;
                 end
        default: stb.outSel = OUT_MARK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmgPrev <= 1'b0;
      txPrev  <= 1'b0;
      rxSamp  <= 1'b1;
      rxState <= RX_IDLE;
      phase   <= '0;
      bitIdx  <= '0;
      lowCnt  <= '0;
    end else begin
      tmgPrev <= tmgIn;
      txPrev  <= txClk;
      if (tmgTick) begin
        rxSamp <= dataIn;
        if (dataIn) lowCnt <= '0;
        else if (lowCnt < brkLimit) lowCnt <= lowCnt + 1'b1;
        phase <= phase + 1'b1;
        unique case (rxState)
          RX_IDLE: if (!dataIn && rxSamp) begin
                     rxState <= RX_START;
                     phase   <= '0;
                   end
          RX_START: if (phase == CW'(OSR / 2 - 1)) begin
                      rxState <= dataIn ? RX_IDLE : RX_BITS;
                      phase   <= '0;
                      bitIdx  <= '0;
                    end
          RX_BITS: if (phase == CW'(OSR - 1)) begin
                     phase  <= '0;
                     bitIdx <= bitIdx + 1'b1;
                     if (bitIdx == nData) rxState <= RX_IDLE;
                   end
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState   <= TX_IDLE;
      txCnt     <= '0;
      credit    <= GW'(BASIC_GAP);
      holdValid <= 1'b0;
    end else begin
      holdValid <= (holdValid & ~stb.txLoad) | stb.rxCommit;
      if (txRise) begin
        unique case (txState)
          TX_IDLE: if (!breakActive && holdValid) begin
                     txState <= TX_DATA;
                     txCnt   <= '0;
                   end
          TX_DATA: begin
            txCnt <= txCnt + 1'b1;
            if (txCnt == nData - 1'b1) txState <= TX_STOP;
          end
          TX_STOP: if (deleteOk) begin
                     txState <= TX_DATA;
                     txCnt   <= '0;
                     credit  <= '0;
                   end else begin
                     txState <= TX_IDLE;
                     if (credit < GW'(BASIC_GAP)) credit <= credit + 1'b1;
                   end
          default: txState <= TX_IDLE;
        endcase
      end
    end
  end

  // R7
  hispeed_no_delete_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hiSpeed && txState == TX_STOP && txRise) |-> !stb.txLoad);
  // R8
  break_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakActive |-> !stb.rxCommit);
  // R2
  commit_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxCommit |=> holdValid);
endmodule

// File: rtl/async_sync_tx_dp.sv
module async_sync_tx_dp
  import async_sync_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    dataIn,
  input  strobe_t stb,
  output logic    outLine
);
  logic [MAX_DATA-1:0] rxData, holdData, txData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData   <= '0;
      holdData <= '0;
      txData   <= '0;
      outLine  <= 1'b1;
    end else begin
      if (stb.rxShift) rxData[stb.rxIdx] <= dataIn;
      if (stb.rxCommit) holdData <= rxData;
      if (stb.txLoad) txData <= holdData;
      else if (stb.txShift) txData <= txData >> 1;
      if (stb.outWr) begin
        unique case (stb.outSel)
          OUT_SPACE: outLine <= 1'b0;
          OUT_DATA:  outLine <= txData[0];
          default:   outLine <= 1'b1;
        endcase
      end
    end
  end

  // R3
  out_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outLine) |-> $past(stb.outWr));
endmodule

// File: rtl/async_sync_tx.sv
module async_sync_tx
  import async_sync_tx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int BASIC_GAP = 8,
  parameter int EXT_GAP   = 4,
  parameter int BRK_CHARS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tmgIn,
  input  logic       txClk,
  input  logic       dataIn,
  input  logic [1:0] lenSel,
  input  logic       extRate,
  input  logic       bypass,
  input  logic       hiSpeed,
  output logic       dataOut
);
  strobe_t stb;
  logic    outLine;

  async_sync_tx_ctrl #(
    .OSR(OSR), .BASIC_GAP(BASIC_GAP), .EXT_GAP(EXT_GAP), .BRK_CHARS(BRK_CHARS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tmgIn(tmgIn), .txClk(txClk), .dataIn(dataIn),
    .lenSel(lenSel), .extRate(extRate), .hiSpeed(hiSpeed), .stb(stb)
  );

  async_sync_tx_dp u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .stb(stb), .outLine(outLine)
  );

  assign dataOut = bypass ? dataIn : outLine;
endmodule

// File: tb/async_sync_tx_tb.sv
module async_sync_tx_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataIn = 1'b1;
  logic [1:0] lenSel = 2'd2;
  logic extRate = 1'b0, bypass = 1'b0, hiSpeed = 1'b0;
  logic dataOut;
  logic [6:0] cnt = '0;

  always #2.5 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 1'b1;

  async_sync_tx u_dut (
    .clk(clk), .rstN(rstN), .tmgIn(cnt[1]), .txClk(cnt[5]), .dataIn(dataIn),
    .lenSel(lenSel), .extRate(extRate), .bypass(bypass), .hiSpeed(hiSpeed),
    .dataOut(dataOut)
  );

  int checks = 0, fails = 0, accE = 0;
  logic [8:0] expQ [0:127];
  int wrIdx = 0, rdIdx = 0;
  logic decOn = 1'b0;
  int decState = 0, k = 0, nd = 8, gapLim = 8;
  int sinceDel = 100, delCount = 0, badChange = 0;
  logic [8:0] acc;
  logic prevOut = 1'b1, sawSpace = 1'b0;
  logic finished = 1'b0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dataBits(input logic [1:0] sel);
    return 6 + int'(sel);
  endfunction

  // output decoder and change-timing monitor
  initial forever begin
    @(posedge clk); #1;
    if (rstN && !bypass && dataOut !== prevOut && cnt[5:0] != 6'd32 && cnt[5:0] != 6'd33)
      badChange++;
    prevOut = dataOut;
    if (dataOut == 1'b0) sawSpace = 1'b1;
    if (decOn && cnt[5:0] == 6'd48) begin
      case (decState)
        0: if (!dataOut) begin decState = 1; k = 0; acc = '0; end
        1: begin
          acc[k] = dataOut;
          k++;
          if (k == nd) begin
            decState = 2;
            if (rdIdx < wrIdx) begin
              check(acc == expQ[rdIdx], "R2 char", int'(acc), int'(expQ[rdIdx]));
              rdIdx++;
            end else check(1'b0, "R2 unexpected frame", int'(acc), -1);
          end
        end
        default: if (dataOut) begin decState = 0; sinceDel++; end
                 else begin
                   check(sinceDel >= gapLim, "R4/R5 deletion spacing", sinceDel, gapLim);
                   delCount++; sinceDel = 0; decState = 1; k = 0; acc = '0;
                 end
      endcase
    end
  end

  task automatic doReset();
    rstN = 1'b0; dataIn = 1'b1; decOn = 1'b0;
    repeat (10) @(negedge clk);
    wrIdx = 0; rdIdx = 0; decState = 0; sinceDel = 100; delCount = 0; accE = 0;
    rstN = 1'b1;
    repeat (200) @(negedge clk);
  endtask

  task automatic holdBit(input logic v, input int durE);
    int n;
    accE += durE;
    n = accE >> 3;
    accE -= n << 3;
    dataIn = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendChar(input logic [8:0] d, input int durE, input int stops);
    expQ[wrIdx] = d & ((9'd1 << nd) - 9'd1);
    wrIdx++;
    holdBit(1'b0, durE);
    for (int i = 0; i < nd; i++) holdBit(d[i], durE);
    for (int i = 0; i < stops; i++) holdBit(1'b1, durE);
  endtask

  task automatic burst(input string req, input logic [1:0] ls, input int n,
                       input int durE, input int maxStops);
    lenSel = ls; nd = dataBits(ls); gapLim = extRate ? 4 : 8;
    decOn = 1'b1;
    for (int i = 0; i < n; i++)
      sendChar(9'($urandom()), durE, 1 + int'($urandom_range(maxStops - 1)));
    repeat (3 * 11 * 64) @(negedge clk);
    check(rdIdx == wrIdx, {req, " all delivered"}, rdIdx, wrIdx);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    void'($urandom(32'h5EED));
    doReset();
    // R1 idle mark after reset
    check(dataOut == 1'b1, "R1 idle after reset", int'(dataOut), 1);

    // R2 nominal rate, every length, random gaps
    for (int l = 0; l < 4; l++) begin
      doReset();
      burst("R2", 2'(l), 6, 512, 3);
      check(delCount == 0, "R2 no deletion at nominal", delCount, 0);
    end

    // R4 basic mode, source 0.8% fast
    doReset(); extRate = 1'b0;
    burst("R4", 2'd2, 32, 508, 1);
    check(delCount > 0, "R4 deletion occurred", delCount, 1);

    // R5 extended mode, source 2.2% fast
    doReset(); extRate = 1'b1;
    burst("R5", 2'd2, 32, 501, 1);
    check(delCount > 0, "R5 deletion occurred", delCount, 1);
    extRate = 1'b0;

    // R6 slow source, 2.3% slow
    doReset();
    sawSpace = 1'b0;
    burst("R6", 2'd3, 12, 524, 1);
    check(delCount == 0, "R6 no deletion when slow", delCount, 0);
    check(dataOut == 1'b1, "R6 idle mark after burst", int'(dataOut), 1);

    // R7 higher-speed mode never deletes
    doReset(); hiSpeed = 1'b1;
    burst("R7", 2'd2, 16, 508, 1);
    check(delCount == 0, "R7 no deletion in higher-speed mode", delCount, 0);
    hiSpeed = 1'b0;

    // R10 short space pulse ignored
    doReset(); sawSpace = 1'b0;
    dataIn = 1'b0; repeat (20) @(negedge clk); dataIn = 1'b1;
    repeat (1500) @(negedge clk);
    check(!sawSpace, "R10 glitch ignored", int'(sawSpace), 0);
    check(dataOut == 1'b1, "R10 output mark", int'(dataOut), 1);

    // R8 break passes as continuous space
    doReset(); lenSel = 2'd1;
    dataIn = 1'b0; repeat (3 * 9 * 64) @(negedge clk);
    check(dataOut == 1'b0, "R8 break is space", int'(dataOut), 0);
    repeat (64) @(negedge clk);
    check(dataOut == 1'b0, "R8 break still space", int'(dataOut), 0);
    dataIn = 1'b1; repeat (3 * 64) @(negedge clk);
    check(dataOut == 1'b1, "R8 mark after break", int'(dataOut), 1);

    // R3 output changes only right after a bit-clock edge
    check(badChange == 0, "R3 change timing", badChange, 0);

    // R9 bypass
    doReset(); bypass = 1'b1;
    for (int i = 0; i < 24; i++) begin
      dataIn = 1'($urandom());
      repeat (1 + int'($urandom_range(5))) @(negedge clk);
      #1;
      check(dataOut == dataIn, "R9 bypass", int'(dataOut), int'(dataIn));
    end
    bypass = 1'b0;
    finish();
  end
endmodule